// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block sits on the upstream side of a bus bridge and decides, for each transaction address it is shown, whether the bridge should claim and forward that transaction. The configuration registers arrive in packed form: an 8-bit I/O base and limit, each with an optional 16-bit upper extension; a 16-bit memory base and limit; and a 16-bit prefetchable base and limit, each with an optional 32-bit upper extension. The block expands these into full inclusive address ranges. The I/O window has a 4 KB step and the memory windows have a 1 MB step. Each limit has its low bits filled with ones.

A request presents a 64-bit address, a type flag (I/O or memory) and a one-cycle strobe. The cycle after the strobe, the block reports which window claimed the address: the I/O window, the memory window, the prefetchable window, or the fixed legacy display ranges. It also reports one combined forward flag. The two command enables gate the windows, and a separate display enable switches the legacy ranges on. A small two-state controller marks the cycle in which the result is fresh. In ST_IDLE, a strobe moves it to ST_REPORT. In ST_REPORT, it returns to ST_IDLE unless another strobe arrives, in which case it stays in ST_REPORT. The hit flags keep their values until the next strobe.

Top module: `bridge_window_decode`

## Requirements
- R1: The I/O base is {upper16, base[7:4], 12'h000}. The upper 16 bits are used only when base[3:0] == 4'h1 (32-bit I/O); otherwise address bits 31:16 of the window are zero. The I/O limit is built the same way from the limit byte, using the limit byte's own low nibble. An I/O request hits the I/O window when base <= address <= limit.
- R2: The low 12 bits of the expanded I/O limit are all ones. An I/O address one above that limit therefore misses.
- R3: The memory base is {mem_base[15:4], 20'h00000} and the memory limit is {mem_limit[15:4], 20'hFFFFF}. Both bounds are inclusive.
- R4: The prefetchable bounds are formed like the R3 bounds. When the low nibble of the base or limit word equals 4'h1 (64-bit), that bound's 32-bit upper register supplies address bits 63:32; otherwise those bits are zero.
- R5: The I/O window and the legacy I/O ranges can hit only while io_space_en is 1. The memory window, the prefetchable window and the legacy memory range can hit only while mem_space_en is 1.
- R6: A window whose expanded limit is below its expanded base never hits.
- R7: While legacy_disp_en is 1, these ranges hit independently of the windows: memory 0xA0000 to 0xBFFFF, I/O 0x3B0 to 0x3BB and I/O 0x3C0 to 0x3DF. While legacy_disp_en is 0, they never hit.
- R8: At most one hit flag is set, with priority legacy display > prefetchable > memory. fwd is 1 exactly when a hit flag is 1.
- R9: res_valid is 1 in the cycle after a req_valid cycle and 0 otherwise. The hit flags and fwd change only in the cycle after a strobe.
- R10: After reset, res_valid, fwd and all hit flags are 0.
- R11: An I/O request never sets hit_mem or hit_pref. A memory request never sets hit_io.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Address strobe, one cycle |
| req_is_io | input | 1 | 1 = I/O request, 0 = memory request |
| req_addr | input | 64 | Request address |
| io_base_b | input | 8 | Packed I/O base byte |
| io_limit_b | input | 8 | Packed I/O limit byte |
| io_base_up | input | 16 | I/O base bits 31:16 |
| io_limit_up | input | 16 | I/O limit bits 31:16 |
| mem_base_w | input | 16 | Packed memory base word |
| mem_limit_w | input | 16 | Packed memory limit word |
| pf_base_w | input | 16 | Packed prefetchable base word |
| pf_limit_w | input | 16 | Packed prefetchable limit word |
| pf_base_up | input | 32 | Prefetchable base bits 63:32 |
| pf_limit_up | input | 32 | Prefetchable limit bits 63:32 |
| io_space_en | input | 1 | Command I/O enable |
| mem_space_en | input | 1 | Command memory enable |
| legacy_disp_en | input | 1 | Legacy display forwarding enable |
| res_valid | output | 1 | Result fresh this cycle |
| hit_io | output | 1 | I/O window hit |
| hit_mem | output | 1 | Memory window hit |
| hit_pref | output | 1 | Prefetchable window hit |
| hit_vga | output | 1 | Legacy display range hit |
| fwd | output | 1 | Any hit |

## Verification
The hardest case to reach is an address claimed by two sources at once. No single window setup shows the priority, so the stimulus deliberately builds overlapping windows. In one setup, a memory window spans the legacy display range. In another, a prefetchable window is set to exactly the same range as the memory window. Each overlap is then probed with the display enable both on and off. The packed upper extensions need similar care: each one is checked against an address whose low bits match the window but whose upper bits do not. This is done with both the 32-bit (or 64-bit) type code and with the narrow type code.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
    localparam int ADDR_W        = 64;
    localparam int IO_GRAN_BITS  = 12;
    localparam int MEM_GRAN_BITS = 20;
    localparam logic [3:0] IO_TYPE_WIDE = 4'h1;
    localparam logic [3:0] PF_TYPE_WIDE = 4'h1;

    typedef enum logic [1:0] {WK_IO, WK_MEM, WK_PREF} win_kind_e;
    typedef enum logic {ST_IDLE, ST_REPORT} dec_state_e;

    typedef struct packed {
        logic io;
        logic mem;
        logic pref;
        logic vga;
    } hit_vec_t;
endpackage

// File: rtl/bwd_win_bounds.sv
module bwd_win_bounds
    import bwd_pkg::*;
#(
    parameter win_kind_e KIND     = WK_MEM,
    parameter bit        IS_LIMIT = 1'b0
) (
    input  logic [15:0]       packed_w,
    input  logic [31:0]       upper_ext,
    output logic [ADDR_W-1:0] bound
);
    generate
        if (KIND == WK_IO) begin : g_io
            logic wide;
            logic unused_bits;
            assign wide        = (packed_w[3:0] == IO_TYPE_WIDE);
            assign unused_bits = ^{packed_w[15:8], upper_ext[31:16]};
            assign bound = {32'h0, (wide ? upper_ext[15:0] : 16'h0),
                            packed_w[7:4], {IO_GRAN_BITS{IS_LIMIT}}};
        end else if (KIND == WK_MEM) begin : g_mem
            logic unused_bits;
            assign unused_bits = ^{packed_w[3:0], upper_ext};
            assign bound = {32'h0, packed_w[15:4], {MEM_GRAN_BITS{IS_LIMIT}}};
        end else begin : g_pref
            logic wide;
            assign wide  = (packed_w[3:0] == PF_TYPE_WIDE);
            assign bound = {(wide ? upper_ext : 32'h0), packed_w[15:4],
                            {MEM_GRAN_BITS{IS_LIMIT}}};
        end
    endgenerate
endmodule

// File: rtl/bwd_range_hit.sv
module bwd_range_hit
    import bwd_pkg::*;
(
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    output logic              hit
);
    assign hit = en && (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/bridge_window_decode.sv
module bridge_window_decode
    import bwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_is_io,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        io_base_b,
    input  logic [7:0]        io_limit_b,
    input  logic [15:0]       io_base_up,
    input  logic [15:0]       io_limit_up,
    input  logic [15:0]       mem_base_w,
    input  logic [15:0]       mem_limit_w,
    input  logic [15:0]       pf_base_w,
    input  logic [15:0]       pf_limit_w,
    input  logic [31:0]       pf_base_up,
    input  logic [31:0]       pf_limit_up,
    input  logic              io_space_en,
    input  logic              mem_space_en,
    input  logic              legacy_disp_en,
    output logic              res_valid,
    output logic              hit_io,
    output logic              hit_mem,
    output logic              hit_pref,
    output logic              hit_vga,
    output logic              fwd
);
    localparam int NWIN = 3;
    localparam int NVGA = 3;
    localparam logic [ADDR_W-1:0] VGA_LO [NVGA] = '{64'hA0000, 64'h3B0, 64'h3C0};
    localparam logic [ADDR_W-1:0] VGA_HI [NVGA] = '{64'hBFFFF, 64'h3BB, 64'h3DF};

    // window index 0 = I/O, 1 = memory, 2 = prefetchable
    logic [15:0]       lo_word [NWIN];
    logic [15:0]       hi_word [NWIN];
    logic [31:0]       lo_up   [NWIN];
    logic [31:0]       hi_up   [NWIN];
    logic [ADDR_W-1:0] win_lo  [NWIN];
    logic [ADDR_W-1:0] win_hi  [NWIN];
    logic [NWIN-1:0]   win_en;
    logic [NWIN-1:0]   win_hit;
    logic [NVGA-1:0]   vga_en;
    logic [NVGA-1:0]   vga_hit;

    assign lo_word[0] = {8'h0, io_base_b};
    assign hi_word[0] = {8'h0, io_limit_b};
    assign lo_up[0]   = {16'h0, io_base_up};
    assign hi_up[0]   = {16'h0, io_limit_up};
    assign lo_word[1] = mem_base_w;
    assign hi_word[1] = mem_limit_w;
    assign lo_up[1]   = 32'h0;
    assign hi_up[1]   = 32'h0;
    assign lo_word[2] = pf_base_w;
    assign hi_word[2] = pf_limit_w;
    assign lo_up[2]   = pf_base_up;
    assign hi_up[2]   = pf_limit_up;

    assign win_en[0] = io_space_en  &&  req_is_io;
    assign win_en[1] = mem_space_en && !req_is_io;
    assign win_en[2] = mem_space_en && !req_is_io;

    assign vga_en[0] = legacy_disp_en && mem_space_en && !req_is_io;
    assign vga_en[1] = legacy_disp_en && io_space_en  &&  req_is_io;
    assign vga_en[2] = legacy_disp_en && io_space_en  &&  req_is_io;

    genvar gi;
    generate
        for (gi = 0; gi < NWIN; gi++) begin : g_win
            localparam win_kind_e K = (gi == 0) ? WK_IO : ((gi == 1) ? WK_MEM : WK_PREF);
            bwd_win_bounds #(.KIND(K), .IS_LIMIT(1'b0)) u_lo (
                .packed_w(lo_word[gi]), .upper_ext(lo_up[gi]), .bound(win_lo[gi]));
            bwd_win_bounds #(.KIND(K), .IS_LIMIT(1'b1)) u_hi (
                .packed_w(hi_word[gi]), .upper_ext(hi_up[gi]), .bound(win_hi[gi]));
            bwd_range_hit u_cmp (
                .en(win_en[gi]), .addr(req_addr), .lo(win_lo[gi]), .hi(win_hi[gi]),
                .hit(win_hit[gi]));
        end
        for (gi = 0; gi < NVGA; gi++) begin : g_vga
            bwd_range_hit u_cmp (
                .en(vga_en[gi]), .addr(req_addr), .lo(VGA_LO[gi]), .hi(VGA_HI[gi]),
                .hit(vga_hit[gi]));
        end
    endgenerate

    // priority: legacy display, then prefetchable, then memory; I/O is exclusive by type
    hit_vec_t sel_d;
    always_comb begin
        sel_d = '0;
        if (|vga_hit)        sel_d.vga  = 1'b1;
        else if (win_hit[2]) sel_d.pref = 1'b1;
        else if (win_hit[1]) sel_d.mem  = 1'b1;
        else if (win_hit[0]) sel_d.io   = 1'b1;
    end

    dec_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid)  state_d = ST_REPORT;
            ST_REPORT: if (!req_valid) state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    hit_vec_t hits_q;
    logic     fwd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hits_q <= '0;
            fwd_q  <= 1'b0;
        end else if (req_valid) begin
            hits_q <= sel_d;
            fwd_q  <= (|vga_hit) || (|win_hit);
        end
    end

    assign res_valid = (state_q == ST_REPORT);
    assign hit_io    = hits_q.io;
    assign hit_mem   = hits_q.mem;
    assign hit_pref  = hits_q.pref;
    assign hit_vga   = hits_q.vga;
    assign fwd       = fwd_q;
endmodule

// File: rtl/bwd_checks.sv
module bwd_checks (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_is_io,
    input logic io_space_en,
    input logic mem_space_en,
    input logic res_valid,
    input logic hit_io,
    input logic hit_mem,
    input logic hit_pref,
    input logic hit_vga,
    input logic fwd
);
    assert_onehot_hits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_io, hit_mem, hit_pref, hit_vga}));

    assert_valid_after_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    assert_no_valid_without_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);

    assert_hold_results_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable({hit_io, hit_mem, hit_pref, hit_vga, fwd}));

    assert_io_type_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_io) |=> !hit_io);

    assert_mem_type_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_io) |=> (!hit_mem && !hit_pref));

    assert_io_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_io && !io_space_en) |=> !fwd);

    assert_mem_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_io && !mem_space_en) |=> !fwd);
endmodule

bind bridge_window_decode bwd_checks u_bwd_checks (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_io(req_is_io),
    .io_space_en(io_space_en), .mem_space_en(mem_space_en),
    .res_valid(res_valid), .hit_io(hit_io), .hit_mem(hit_mem),
    .hit_pref(hit_pref), .hit_vga(hit_vga), .fwd(fwd));

// File: tb/tb_bridge_window_decode.sv
module tb_bridge_window_decode;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_is_io = 1'b0;
    logic [63:0] req_addr = '0;
    logic [7:0]  io_base_b = '0, io_limit_b = '0;
    logic [15:0] io_base_up = '0, io_limit_up = '0;
    logic [15:0] mem_base_w = '0, mem_limit_w = '0, pf_base_w = '0, pf_limit_w = '0;
    logic [31:0] pf_base_up = '0, pf_limit_up = '0;
    logic        io_space_en = 1'b0, mem_space_en = 1'b0, legacy_disp_en = 1'b0;
    logic        res_valid, hit_io, hit_mem, hit_pref, hit_vga, fwd;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bridge_window_decode dut (.*);

    // {req(4), is_io(1), addr(64), expected {io,mem,pref,vga}(4)}
    localparam int NV = 24;
    localparam logic [72:0] VEC [NV] = '{
        {4'd1,  1'b1, 64'h0000_0001_2000, 4'b1000},  // R1 base inclusive
        {4'd2,  1'b1, 64'h0000_0001_3FFF, 4'b1000},  // R2 filled limit
        {4'd2,  1'b1, 64'h0000_0001_4000, 4'b0000},  // R2 one above limit
        {4'd1,  1'b1, 64'h0000_0000_2000, 4'b0000},  // R1 upper16 mismatch
        {4'd1,  1'b1, 64'h0000_0001_1FFF, 4'b0000},  // R1 below base
        {4'd3,  1'b0, 64'h0000_1230_0000, 4'b0100},  // R3 base
        {4'd3,  1'b0, 64'h0000_125F_FFFF, 4'b0100},  // R3 limit
        {4'd3,  1'b0, 64'h0000_1260_0000, 4'b0000},  // R3 above
        {4'd3,  1'b0, 64'h0000_122F_FFFF, 4'b0000},  // R3 below
        {4'd4,  1'b0, 64'h0002_4000_0000, 4'b0010},  // R4 base with upper
        {4'd4,  1'b0, 64'h0002_410F_FFFF, 4'b0010},  // R4 limit with upper
        {4'd4,  1'b0, 64'h0000_4000_0000, 4'b0000},  // R4 upper missing
        {4'd4,  1'b0, 64'h0002_4110_0000, 4'b0000},  // R4 above
        {4'd7,  1'b0, 64'h0000_000A_0000, 4'b0001},  // R7 legacy mem low
        {4'd7,  1'b0, 64'h0000_000B_FFFF, 4'b0001},  // R7 legacy mem high
        {4'd7,  1'b0, 64'h0000_000C_0000, 4'b0000},  // R7 above
        {4'd7,  1'b1, 64'h0000_0000_03B0, 4'b0001},  // R7 io A low
        {4'd7,  1'b1, 64'h0000_0000_03BB, 4'b0001},  // R7 io A high
        {4'd7,  1'b1, 64'h0000_0000_03BC, 4'b0000},  // R7 gap
        {4'd7,  1'b1, 64'h0000_0000_03C0, 4'b0001},  // R7 io B low
        {4'd7,  1'b1, 64'h0000_0000_03DF, 4'b0001},  // R7 io B high
        {4'd7,  1'b1, 64'h0000_0000_03E0, 4'b0000},  // R7 above B
        {4'd11, 1'b0, 64'h0000_0001_2000, 4'b0000},  // R11 io address as memory
        {4'd11, 1'b1, 64'h0000_1230_0000, 4'b0000}   // R11 memory address as io
    };

    task automatic check(input string tag, input logic [3:0] exp, input logic exp_valid);
        logic [3:0] got;
        got = {hit_io, hit_mem, hit_pref, hit_vga};
        checks++;
        if (got !== exp || fwd !== (|exp) || res_valid !== exp_valid) begin
            failures++;
            $display("FAIL %s hits=%b fwd=%b valid=%b expected hits=%b fwd=%b valid=%b",
                     tag, got, fwd, res_valid, exp, |exp, exp_valid);
        end
    endtask

    // drive a strobe at a falling edge; result is sampled at the next falling edge
    task automatic probe(input logic is_io, input logic [63:0] a);
        @(negedge clk);
        req_is_io = is_io; req_addr = a; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic base_cfg();
        io_base_b = 8'h21;  io_base_up = 16'h0001;
        io_limit_b = 8'h31; io_limit_up = 16'h0001;
        mem_base_w = 16'h1230; mem_limit_w = 16'h1250;
        pf_base_w = 16'h4001;  pf_base_up = 32'h2;
        pf_limit_w = 16'h4101; pf_limit_up = 32'h2;
        io_space_en = 1'b1; mem_space_en = 1'b1; legacy_disp_en = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 outputs during reset", 4'b0000, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 outputs after reset", 4'b0000, 1'b0);

        base_cfg();
        for (int i = 0; i < NV; i++) begin
            probe(VEC[i][68], VEC[i][67:4]);
            check($sformatf("R%0d vector %0d", VEC[i][72:69], i), VEC[i][3:0], 1'b1);
        end

        // R9: hold after result cycle, no valid without strobe
        probe(1'b0, 64'h1240_0000);
        check("R9 result cycle", 4'b0100, 1'b1);
        req_addr = 64'h0;
        @(negedge clk);
        check("R9 held without strobe", 4'b0100, 1'b0);

        // R5: enables gate every window and legacy range
        io_space_en = 1'b0;
        probe(1'b1, 64'h1_2000);  check("R5 io window gated", 4'b0000, 1'b1);
        probe(1'b1, 64'h3C0);     check("R5 legacy io gated", 4'b0000, 1'b1);
        io_space_en = 1'b1; mem_space_en = 1'b0;
        probe(1'b0, 64'h1230_0000);   check("R5 mem gated", 4'b0000, 1'b1);
        probe(1'b0, 64'h2_4000_0000); check("R5 pref gated", 4'b0000, 1'b1);
        probe(1'b0, 64'hA0000);       check("R5 legacy mem gated", 4'b0000, 1'b1);
        mem_space_en = 1'b1;

        // R7: legacy display disable
        legacy_disp_en = 1'b0;
        probe(1'b1, 64'h3B0);   check("R7 legacy off io", 4'b0000, 1'b1);
        probe(1'b0, 64'hA0000); check("R7 legacy off mem", 4'b0000, 1'b1);
        legacy_disp_en = 1'b1;

        // R6: limit below base
        mem_limit_w = 16'h1220;
        probe(1'b0, 64'h1230_0000); check("R6 empty mem base", 4'b0000, 1'b1);
        probe(1'b0, 64'h122F_FFFF); check("R6 empty mem limit", 4'b0000, 1'b1);
        io_limit_b = 8'h11;
        probe(1'b1, 64'h1_2000);    check("R6 empty io", 4'b0000, 1'b1);
        base_cfg();

        // R1: narrow I/O type ignores upper register
        io_base_b = 8'h20; io_limit_b = 8'h30;
        probe(1'b1, 64'h2000);   check("R1 16-bit io base", 4'b1000, 1'b1);
        probe(1'b1, 64'h1_2000); check("R1 16-bit io upper ignored", 4'b0000, 1'b1);
        base_cfg();

        // R4: 32-bit prefetchable type ignores upper register
        pf_base_w = 16'h4000; pf_limit_w = 16'h4100;
        probe(1'b0, 64'h4000_0000);   check("R4 32-bit pref", 4'b0010, 1'b1);
        probe(1'b0, 64'h2_4000_0000); check("R4 32-bit pref upper ignored", 4'b0000, 1'b1);

        // R8: priority on overlaps
        mem_base_w = 16'h0000; mem_limit_w = 16'h0000;
        probe(1'b0, 64'hA0000); check("R8 legacy over mem", 4'b0001, 1'b1);
        legacy_disp_en = 1'b0;
        probe(1'b0, 64'hA0000); check("R8 mem when legacy off", 4'b0100, 1'b1);
        pf_base_w = 16'h0000; pf_limit_w = 16'h0000;
        probe(1'b0, 64'h50000); check("R8 pref over mem", 4'b0010, 1'b1);
        legacy_disp_en = 1'b1;
        probe(1'b0, 64'hB0000); check("R8 legacy over pref", 4'b0001, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule